// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block is the multi-cycle engine that a small 16-bit segmented core uses to enter and leave interrupt handlers. When the core raises a take-interrupt strobe along with an 8-bit vector number, the sequencer saves the machine context on the stack. It then clears the single-step trap flag and the interrupt-enable flag. Last, it reads the handler's code segment and instruction pointer from a fixed table that starts at physical address zero. When the core raises a return strobe, the sequencer pops the saved context back.

All memory traffic goes over one 16-bit word port with a valid/ready handshake. The stack is addressed as stack segment times 16 plus stack pointer, and the result is kept to 20 bits. Each vector entry is four bytes, so the whole table occupies the first 1 KiB. While the block is idle, its register outputs simply mirror the core's current register inputs. Once a sequence starts, the outputs show the sequencer's working copies. A one-cycle done pulse marks the cycle in which the final values are presented.

Top module: `irq_vec_seq`

## Requirements
- R1: After reset and whenever the block is idle, mem_valid_o and done_o are low and flags_o, cs_o, ip_o, sp_o equal flags_i, cs_i, ip_i, sp_i.
- R2: An accepted take request produces three writes (mem_we_o high) in this order: the FLAGS value sampled at the request, then CS, then IP. They go to stack offsets SP-2, SP-4 and SP-6.
- R3: Every stack access uses physical address (ss_i*16 + offset) modulo 2^20. The offset wraps modulo 2^16 before it is added.
- R4: After the pushes, the new FLAGS equals the sampled FLAGS with bit 8 (trap) and bit 9 (interrupt enable) cleared and all other bits kept.
- R5: After the pushes, two reads (mem_we_o low) fetch the new IP from byte address vec*4 and then the new CS from vec*4+2. Both addresses are below 1024.
- R6: An accepted return request produces three reads in this order: IP from SS:SP, CS from SS:SP+2, FLAGS from SS:SP+4. The final outputs are those words, including bits 8 and 9, and the final SP is SP+6.
- R7: After an entry sequence, the final SP is the sampled SP minus 6, modulo 2^16.
- R8: While mem_valid_o is high and mem_ready_i is low, the sequencer holds its access with mem_we_o, mem_addr_o and mem_wdata_o unchanged and does not advance.
- R9: done_o is high for exactly one cycle. That cycle follows the clock edge that accepts the last transfer, and in it the outputs show the final register values. The block is idle in the next cycle.
- R10: A take or return request that arrives while a sequence is running, including its done cycle, is ignored.
- R11: If take_i and ret_i are both high in an idle cycle, the entry sequence is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | Take-interrupt strobe |
| vec_i | input | 8 | Vector number for the take request |
| ret_i | input | 1 | Interrupt-return strobe |
| flags_i | input | 16 | Current FLAGS |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | IP of the next instruction |
| sp_i | input | 16 | Current stack pointer |
| ss_i | input | 16 | Current stack segment |
| mem_valid_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 20 | Physical byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_ready_i | input | 1 | Access accepted at this clock edge |
| mem_rdata_i | input | 16 | Read data, valid with mem_ready_i |
| flags_o | output | 16 | New FLAGS |
| cs_o | output | 16 | New CS |
| ip_o | output | 16 | New IP |
| sp_o | output | 16 | New SP |
| done_o | output | 1 | Sequence complete, one cycle |

## Verification
With the memory always ready, the first access appears in the cycle after the request edge. Each later access appears one cycle after the previous one is accepted. done_o follows one cycle after the last acceptance, which gives six cycles for an entry and four for a return, plus one cycle for every stalled cycle. The bench keeps a queue of the accesses it expects and retires the front entry only on a cycle in which it drove ready. It samples at the falling edge, so the expected access, done pulse and result values are each compared in exactly the cycle the registered design presents them.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned PHYS_W = 20;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned TF_POS = 8;
  localparam int unsigned IF_POS = 9;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PSH_FL,
    S_PSH_CS,
    S_PSH_IP,
    S_VEC_IP,
    S_VEC_CS,
    S_POP_IP,
    S_POP_CS,
    S_POP_FL,
    S_DONE
  } seq_state_e;

  function automatic logic is_push(seq_state_e s);
    return (s == S_PSH_FL) || (s == S_PSH_CS) || (s == S_PSH_IP);
  endfunction

  function automatic logic is_pop(seq_state_e s);
    return (s == S_POP_IP) || (s == S_POP_CS) || (s == S_POP_FL);
  endfunction

  function automatic logic is_vec(seq_state_e s);
    return (s == S_VEC_IP) || (s == S_VEC_CS);
  endfunction

  function automatic logic is_mem(seq_state_e s);
    return is_push(s) || is_pop(s) || is_vec(s);
  endfunction
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic       ret_i,
  input  logic       ready_i,
  output seq_state_e state_o,
  output logic       load_o,
  output logic       step_o
);

  seq_state_e state_q, state_d, succ;
  logic       mem_st;

  always_comb begin
    case (state_q)
      S_IDLE:   succ = take_i ? S_PSH_FL : (ret_i ? S_POP_IP : S_IDLE);
      S_PSH_FL: succ = S_PSH_CS;
      S_PSH_CS: succ = S_PSH_IP;
      S_PSH_IP: succ = S_VEC_IP;
      S_VEC_IP: succ = S_VEC_CS;
      S_VEC_CS: succ = S_DONE;
      S_POP_IP: succ = S_POP_CS;
      S_POP_CS: succ = S_POP_FL;
      S_POP_FL: succ = S_DONE;
      default:  succ = S_IDLE;
    endcase
  end

  assign mem_st  = is_mem(state_q);
  // memory states wait for the handshake
  assign state_d = (mem_st && !ready_i) ? state_q : succ;
  assign step_o  = mem_st && ready_i;
  assign load_o  = (state_q == S_IDLE) && (take_i || ret_i);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  a_r10_entry_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PSH_FL) |-> ($past(state_q) == S_IDLE || $past(state_q) == S_PSH_FL));

  a_r10_return_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POP_IP) |-> ($past(state_q) == S_IDLE || $past(state_q) == S_POP_IP));

  a_r9_done_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DONE) |=> (state_q == S_IDLE));

  a_r11_take_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && take_i && ret_i) |=> (state_q == S_PSH_FL));

endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int unsigned DW  = WORD_W,
  parameter int unsigned AW  = PHYS_W,
  parameter int unsigned VW  = VEC_W,
  parameter int unsigned TFB = TF_POS,
  parameter int unsigned IFB = IF_POS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  seq_state_e    state_i,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] flags_i,
  input  logic [DW-1:0] cs_i,
  input  logic [DW-1:0] ip_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] ss_i,
  input  logic [VW-1:0] vec_i,
  input  logic [DW-1:0] rdata_i,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] flags_o,
  output logic [DW-1:0] cs_o,
  output logic [DW-1:0] ip_o,
  output logic [DW-1:0] sp_o
);

  localparam int unsigned SEG_SH = AW - DW;
  localparam int unsigned TBL_W  = VW + 2;
  localparam logic [DW-1:0] STEP = DW'(2);
  localparam logic [DW-1:0] CLR_MASK = (DW'(1) << TFB) | (DW'(1) << IFB);

  logic [DW-1:0] fl_q, cs_q, ip_q, sp_q, ss_q;
  logic [VW-1:0] vec_q;
  logic [DW-1:0] stk_off;
  logic [AW-1:0] seg_base, stk_addr, tbl_addr;
  logic          idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q  <= '0;
      cs_q  <= '0;
      ip_q  <= '0;
      sp_q  <= '0;
      ss_q  <= '0;
      vec_q <= '0;
    end else if (load_i) begin
      fl_q  <= flags_i;
      cs_q  <= cs_i;
      ip_q  <= ip_i;
      sp_q  <= sp_i;
      ss_q  <= ss_i;
      vec_q <= vec_i;
    end else if (step_i) begin
      case (state_i)
        S_PSH_FL, S_PSH_CS: sp_q <= sp_q - STEP;
        S_PSH_IP: begin
          sp_q <= sp_q - STEP;
          fl_q <= fl_q & ~CLR_MASK;
        end
        S_VEC_IP: ip_q <= rdata_i;
        S_VEC_CS: cs_q <= rdata_i;
        S_POP_IP: begin
          ip_q <= rdata_i;
          sp_q <= sp_q + STEP;
        end
        S_POP_CS: begin
          cs_q <= rdata_i;
          sp_q <= sp_q + STEP;
        end
        S_POP_FL: begin
          fl_q <= rdata_i;
          sp_q <= sp_q + STEP;
        end
        default: ;
      endcase
    end
  end

  // pushes pre-decrement, pops read at the current SP
  assign stk_off  = is_push(state_i) ? (sp_q - STEP) : sp_q;
  assign seg_base = {ss_q, SEG_SH'(0)};
  assign stk_addr = seg_base + {SEG_SH'(0), stk_off};
  assign tbl_addr = AW'({vec_q, (state_i == S_VEC_CS), 1'b0});

  assign mem_valid_o = is_mem(state_i);
  assign mem_we_o    = is_push(state_i);
  assign mem_addr_o  = is_vec(state_i) ? tbl_addr : stk_addr;

  always_comb begin
    case (state_i)
      S_PSH_FL: mem_wdata_o = fl_q;
      S_PSH_CS: mem_wdata_o = cs_q;
      default:  mem_wdata_o = ip_q;
    endcase
  end

  assign idle    = (state_i == S_IDLE);
  assign flags_o = idle ? flags_i : fl_q;
  assign cs_o    = idle ? cs_i : cs_q;
  assign ip_o    = idle ? ip_i : ip_q;
  assign sp_o    = idle ? sp_i : sp_q;

  a_r4_tf_if_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_vec(state_i) |-> (!fl_q[TFB] && !fl_q[IFB]));

  a_r5_vec_in_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_vec(state_i) |-> (mem_addr_o[AW-1:TBL_W] == '0));

  a_r2_push_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && is_push(state_i)) |=> (sp_q == $past(sp_q) - STEP));

  a_r6_pop_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && is_pop(state_i)) |=> (sp_q == $past(sp_q) + STEP));

endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
  import irq_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              ret_i,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] ss_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [PHYS_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] flags_o,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              done_o
);

  seq_state_e state;
  logic       load, step;

  irq_seq_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take_i),
    .ret_i   (ret_i),
    .ready_i (mem_ready_i),
    .state_o (state),
    .load_o  (load),
    .step_o  (step)
  );

  irq_seq_dp #(
    .DW  (WORD_W),
    .AW  (PHYS_W),
    .VW  (VEC_W),
    .TFB (TF_POS),
    .IFB (IF_POS)
  ) i_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .load_i      (load),
    .step_i      (step),
    .flags_i     (flags_i),
    .cs_i        (cs_i),
    .ip_i        (ip_i),
    .sp_i        (sp_i),
    .ss_i        (ss_i),
    .vec_i       (vec_i),
    .rdata_i     (mem_rdata_i),
    .mem_valid_o (mem_valid_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .flags_o     (flags_o),
    .cs_o        (cs_o),
    .ip_o        (ip_o),
    .sp_o        (sp_o)
  );

  assign done_o = (state == S_DONE);

  a_r8_hold_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_no_access_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_valid_o);

endmodule

// File: tb/test_irq_vec_seq.sv
module test_irq_vec_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        take_i = 1'b0, ret_i = 1'b0;
  logic [7:0]  vec_i = '0;
  logic [15:0] flags_i = '0, cs_i = '0, ip_i = '0, sp_i = '0, ss_i = '0;
  logic        mem_valid_o, mem_we_o, mem_ready_i = 1'b0, done_o;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i = '0;
  logic [15:0] flags_o, cs_o, ip_o, sp_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_seq i_irq_vec_seq (
    .clk_i(clk), .rst_ni(rst_ni), .take_i(take_i), .vec_i(vec_i), .ret_i(ret_i),
    .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i), .sp_i(sp_i), .ss_i(ss_i),
    .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .flags_o(flags_o), .cs_o(cs_o), .ip_o(ip_o), .sp_o(sp_o), .done_o(done_o)
  );

  typedef struct {
    bit          we;
    int          addr;
    logic [15:0] wd;
    int          kind;   // 0 write, 1 ip, 2 cs, 3 flags
    string       tag;
  } op_t;

  int errors = 0, checks = 0, cyc = 0;
  op_t q[$];
  logic [15:0] bmem [int];
  int  ph = 0;           // 0 idle, 1 busy, 2 done
  logic [15:0] e_fl, e_cs, e_ip, e_sp;
  string e_fl_tag = "R4", e_ci_tag = "R5", e_sp_tag = "R7";
  bit  ign_seen = 0, prev_ign = 0, prev_stall = 0;
  int  stall_addr = 0;
  int  ready_mode = 0;
  logic d_rst = 1'b0;
  logic [15:0] d_fl = '0, d_cs = '0, d_ip = '0, d_sp = '0, d_ss = '0;
  logic [7:0]  d_vec = '0;

  function automatic int phys(logic [15:0] s, logic [15:0] o);
    return ((int'(s) << 4) + int'(o)) & 'hFFFFF;
  endfunction

  function automatic logic [15:0] rd(int a);
    if (bmem.exists(a)) return bmem[a];
    return a[15:0] ^ 16'hC35A;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic push_op(bit we, int addr, logic [15:0] wd, int kind, string tag);
    op_t o;
    o.we = we; o.addr = addr; o.wd = wd; o.kind = kind; o.tag = tag;
    q.push_back(o);
  endtask

  task automatic build_entry(bit both);
    push_op(1, phys(d_ss, d_sp - 16'd2), d_fl, 0, both ? "R11" : "R2");
    push_op(1, phys(d_ss, d_sp - 16'd4), d_cs, 0, "R2");
    push_op(1, phys(d_ss, d_sp - 16'd6), d_ip, 0, "R2");
    push_op(0, int'(d_vec) * 4,     '0, 1, "R5");
    push_op(0, int'(d_vec) * 4 + 2, '0, 2, "R5");
    e_fl = d_fl & ~16'h0300;
    e_sp = d_sp - 16'd6;
    e_fl_tag = "R4"; e_ci_tag = "R5"; e_sp_tag = "R7";
  endtask

  task automatic build_ret();
    push_op(0, phys(d_ss, d_sp),         '0, 1, "R6");
    push_op(0, phys(d_ss, d_sp + 16'd2), '0, 2, "R6");
    push_op(0, phys(d_ss, d_sp + 16'd4), '0, 3, "R6");
    e_sp = d_sp + 16'd6;
    e_fl_tag = "R6"; e_ci_tag = "R6"; e_sp_tag = "R6";
  endtask

  // one cycle: check at falling edge, drive for next rising edge, advance model
  task automatic step(bit tk, bit rt);
    bit rdy;
    @(negedge clk);
    cyc++;
    if (ph == 0) begin
      chk(prev_ign ? "R10" : "R1", "idle valid", mem_valid_o, 0);
      chk("R1", "idle done", done_o, 0);
      chk("R1", "flags pass", flags_o, flags_i);
      chk("R1", "cs pass", cs_o, cs_i);
      chk("R1", "ip pass", ip_o, ip_i);
      chk("R1", "sp pass", sp_o, sp_i);
    end else if (ph == 1) begin
      chk("R8", "valid", mem_valid_o, 1);
      chk(q[0].tag, "we", mem_we_o, q[0].we);
      chk("R3", "addr", mem_addr_o, q[0].addr);
      if (q[0].we) chk(q[0].tag, "wdata", mem_wdata_o, q[0].wd);
      if (prev_stall) chk("R8", "addr hold", mem_addr_o, stall_addr);
      chk("R9", "early done", done_o, 0);
    end else begin
      chk("R9", "done", done_o, 1);
      chk("R9", "valid in done", mem_valid_o, 0);
      chk(e_fl_tag, "flags", flags_o, e_fl);
      chk(e_ci_tag, "cs", cs_o, e_cs);
      chk(e_ci_tag, "ip", ip_o, e_ip);
      chk(e_sp_tag, "sp", sp_o, e_sp);
      if (ign_seen) chk("R10", "sp after ignored req", sp_o, e_sp);
    end
    prev_ign = 0;
    // drive
    rst_ni = d_rst;
    take_i = tk; ret_i = rt; vec_i = d_vec;
    flags_i = d_fl; cs_i = d_cs; ip_i = d_ip; sp_i = d_sp; ss_i = d_ss;
    case (ready_mode)
      1:       rdy = (cyc % 3) != 0;
      2:       rdy = cyc[0];
      default: rdy = 1'b1;
    endcase
    mem_ready_i = rdy;
    mem_rdata_i = (ph == 1 && !q[0].we) ? rd(q[0].addr) : 16'hDEAD;
    prev_stall = 0;
    // model
    if (d_rst) begin
      case (ph)
        0: begin
          if (tk) begin build_entry(rt); ph = 1; ign_seen = 0; end
          else if (rt) begin build_ret(); ph = 1; ign_seen = 0; end
        end
        1: begin
          if (tk || rt) ign_seen = 1;
          if (rdy) begin
            op_t o;
            o = q.pop_front();
            if (o.we) bmem[o.addr] = o.wd;
            else case (o.kind)
              1: e_ip = rd(o.addr);
              2: e_cs = rd(o.addr);
              default: e_fl = rd(o.addr);
            endcase
            if (q.size() == 0) ph = 2;
          end else begin
            prev_stall = 1;
            stall_addr = q[0].addr;
          end
        end
        default: begin
          if (tk || rt) prev_ign = 1;
          ph = 0;
        end
      endcase
    end
  endtask

  task automatic run_to_idle();
    for (int i = 0; i < 80 && ph != 0; i++) step(0, 0);
    step(0, 0);
  endtask

  task automatic set_regs(logic [15:0] fl, logic [15:0] cs, logic [15:0] ip,
                          logic [15:0] sp, logic [15:0] ss, logic [7:0] v);
    d_fl = fl; d_cs = cs; d_ip = ip; d_sp = sp; d_ss = ss; d_vec = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // vector table contents
    bmem[0]     = 16'h1111; bmem[2]     = 16'h2222;
    bmem[32'h84] = 16'h0A0A; bmem[32'h86] = 16'hB0B0;
    bmem[32'h3FC] = 16'hFEED; bmem[32'h3FE] = 16'hF00D;
    bmem[32'h1C] = 16'h7777; bmem[32'h1E] = 16'h8888;

    // R1: reset state and passthrough
    set_regs(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h1357, 8'h00);
    step(0, 0); step(0, 0);
    d_rst = 1'b1;
    step(0, 0);
    set_regs(16'hAAAA, 16'h5555, 16'h0F0F, 16'hF0F0, 16'h2000, 8'h00);
    step(0, 0); step(0, 0);

    // R2 R4 R5 R7: entry, vector 0, trap and enable set
    set_regs(16'hF3D5, 16'h1000, 16'h0123, 16'h0100, 16'h3000, 8'h00);
    step(1, 0);
    run_to_idle();

    // R6: return from the frame just pushed, flags restored with bits 8/9
    set_regs(16'h0002, 16'h2222, 16'h1111, 16'h00FA, 16'h3000, 8'h00);
    step(0, 1);
    run_to_idle();

    // R8: vector 255 with stalls
    ready_mode = 1;
    set_regs(16'h0300, 16'hC000, 16'h4444, 16'h8000, 16'h0400, 8'hFF);
    step(1, 0);
    run_to_idle();

    // R10: vector 0x21, alternate ready, requests during the sequence
    ready_mode = 2;
    set_regs(16'h0246, 16'h1A2B, 16'h3C4D, 16'h0200, 16'h0500, 8'h21);
    step(1, 0);
    for (int i = 0; i < 40 && ph != 0; i++) step(i[0], !i[0]);
    run_to_idle();

    // R10: return held through the done cycle
    ready_mode = 0;
    set_regs(16'h0000, 16'h0001, 16'h0002, 16'h01FA, 16'h0500, 8'h00);
    step(0, 1);
    for (int i = 0; i < 20 && ph != 2; i++) step(0, 0);
    step(0, 1);
    run_to_idle();

    // R11: both strobes together, take wins
    set_regs(16'h0200, 16'h4321, 16'h8765, 16'h0300, 16'h0600, 8'h07);
    step(1, 1);
    run_to_idle();

    // R3: stack wrap in offset and in 20-bit address
    ready_mode = 1;
    set_regs(16'h0F00, 16'h0ABC, 16'h0DEF, 16'h0004, 16'hFFFF, 8'h21);
    step(1, 0);
    run_to_idle();
    set_regs(16'h0000, 16'h0000, 16'h0000, 16'hFFFE, 16'hFFFF, 8'h00);
    step(0, 1);
    run_to_idle();

    step(0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule